// File: doc/BRIEF.md
# Stop-Mode Entry and Wake Controller

This block decides when a microcontroller core drops into its clock-stopped low-power state and how it comes back out. A decoded stop-instruction strobe either parks the block (oscillator and core clocks off) or, when the stop-disable mask bit is set, is reported as a no-op. While parked, the block watches the IRQ and XIRQ pins, a keyboard-interrupt request and a pending edge-IRQ flag, and decides both whether a wake is allowed and what the core does next. The core either resumes at the next instruction, starts interrupt stacking for XIRQ, or runs a full reset sequence.

An oscillator restart delay of `DELAY_CYC` cycles is placed between a wake and the release of the core clock. A software-writable delay-control bit skips it on ordinary wakes. Any reset sets that bit again. Power-on reset always applies the delay. A reset that arrives while clocks are running never applies it.

The block is clocked from a free-running reference clock. Wake inputs pass through a synchroniser of `SYNC_STAGES` flops. `osc_en` and `core_en` are the clock enables it hands to the oscillator and the core.

Top module: `stop_wake_ctrl`

## Requirements
- R1: In the running state, `stop_strobe` with `stop_dis`=1 gives `nop_pulse`=1 for one cycle after the edge, and `core_en` stays 1.
- R2: In the running state, `stop_strobe` with `stop_dis`=0 drives `core_en`=0 and `osc_en`=0 from the next cycle. Both stay low until a wake or a reset.
- R3: When stopped, `irq_n`=0 wakes the block only while `irq_mask`=0. With `irq_mask`=1 the block stays stopped.
- R4: When stopped, `xirq_n`=0 wakes the block whatever `xirq_mask` holds. With `xirq_mask`=0 the wake ends in `stack_pulse`. With `xirq_mask`=1 it ends in `resume_pulse`, and no `stack_pulse` follows.
- R5: When stopped, `kbd_req`=1 or `edge_pend`=1 wakes the block and ends in `resume_pulse`.
- R6: A wake input takes effect at the second clock edge after the one that first samples it (SYNC_STAGES=2).
- R7: With `dly_bit`=1, a wake gives exactly DELAY_CYC cycles of `delay_busy`=1 with `osc_en`=1 and `core_en`=0. After that, `core_en` rises together with the exit pulse.
- R8: With `dly_bit`=0, a wake raises `core_en` and the exit pulse directly, and `delay_busy` never rises.
- R9: `rst` while stopped or delaying applies a DELAY_CYC delay that starts again from zero. That delay ends in `reset_go` and gives no `resume_pulse` or `stack_pulse`.
- R10: `rst` while running gives `reset_go`=1 in the next cycle. `core_en` stays 1 and no delay is applied.
- R11: `por` holds `core_en`=0, `delay_busy`=1 and `dly_bit`=1. After its release, DELAY_CYC busy cycles end in `reset_go`.
- R12: `dly_bit` is written from `dly_wr_val` when `dly_wr_en`=1 in the running state, and it is set to 1 by `rst` or `por`.
- R13: `stop_strobe` has no effect outside the running state: no `nop_pulse`, no change of clock enables.
- R14: If a wake condition already holds when stop is entered, the block spends exactly one cycle stopped and then wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Ordinary reset, synchronous, active high |
| stop_strobe | input | 1 | Decoded stop-instruction strobe |
| stop_dis | input | 1 | Stop-disable mask bit |
| irq_mask | input | 1 | IRQ mask bit |
| xirq_mask | input | 1 | XIRQ mask bit |
| irq_n | input | 1 | IRQ pin, active low |
| xirq_n | input | 1 | XIRQ pin, active low |
| kbd_req | input | 1 | Keyboard-interrupt request |
| edge_pend | input | 1 | Pending edge-triggered IRQ flag |
| dly_wr_en | input | 1 | Software write strobe for the delay-control bit |
| dly_wr_val | input | 1 | Value written to the delay-control bit |
| osc_en | output | 1 | Oscillator clock enable |
| core_en | output | 1 | Core clock enable |
| nop_pulse | output | 1 | Stop strobe treated as no-op |
| resume_pulse | output | 1 | Resume at the next instruction |
| stack_pulse | output | 1 | Begin XIRQ interrupt stacking |
| reset_go | output | 1 | Release into the reset sequence |
| delay_busy | output | 1 | Restart-delay counter running |
| dly_bit | output | 1 | Current delay-control bit |

## Verification
The bench builds the block with DELAY_CYC=16 and SYNC_STAGES=2. With these values every full restart delay after power-on, after a reset while stopped, and after a delayed wake fits into a few dozen cycles, so its exact length can be counted. The short synchroniser pins the wake latency to a fixed number of edges. The bench checks it together with the one-cycle pass-through stop and the masked-XIRQ resume path.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2
  } swc_state_t;

  typedef enum logic [1:0] {
    EX_RESUME = 2'd0,
    EX_STACK  = 2'd1,
    EX_RESET  = 2'd2
  } swc_exit_t;

  localparam int WAKE_SRCS = 4;
  localparam logic [WAKE_SRCS-1:0] WAKE_IDLE = 4'b0011;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= INIT;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= INIT;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swc_wake_eval.sv
module swc_wake_eval
  import swc_pkg::*;
(
  input  logic      irq_n_s,
  input  logic      xirq_n_s,
  input  logic      kbd_s,
  input  logic      edge_s,
  input  logic      irq_mask,
  input  logic      xirq_mask,
  output logic      wake,
  output swc_exit_t exit_kind
);
  logic irq_ok, xirq_low;

  always_comb begin
    irq_ok    = !irq_n_s && !irq_mask;
    xirq_low  = !xirq_n_s;
    wake      = irq_ok || xirq_low || kbd_s || edge_s;
    exit_kind = (xirq_low && !xirq_mask) ? EX_STACK : EX_RESUME;
  end
endmodule

// File: rtl/swc_delay_cnt.sv
module swc_delay_cnt #(
  parameter int CYCLES = 4096
) (
  input  logic clk,
  input  logic clr,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int DELAY_CYC   = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic rst,
  input  logic stop_strobe,
  input  logic stop_dis,
  input  logic irq_mask,
  input  logic xirq_mask,
  input  logic irq_n,
  input  logic xirq_n,
  input  logic kbd_req,
  input  logic edge_pend,
  input  logic dly_wr_en,
  input  logic dly_wr_val,
  output logic osc_en,
  output logic core_en,
  output logic nop_pulse,
  output logic resume_pulse,
  output logic stack_pulse,
  output logic reset_go,
  output logic delay_busy,
  output logic dly_bit
);
  swc_state_t st;
  swc_exit_t  ex_q, wake_ex;
  logic       wake, cnt_done, cnt_clr;
  logic [WAKE_SRCS-1:0] raw_w, sync_w;
  logic       nop_q, res_q, stk_q, rgo_q, dly_q;

  assign raw_w = {edge_pend, kbd_req, xirq_n, irq_n};

  swc_sync #(.STAGES(SYNC_STAGES), .W(WAKE_SRCS), .INIT(WAKE_IDLE)) u_sync (
    .clk(clk), .rst(por), .d(raw_w), .q(sync_w)
  );

  swc_wake_eval u_eval (
    .irq_n_s(sync_w[0]), .xirq_n_s(sync_w[1]), .kbd_s(sync_w[2]),
    .edge_s(sync_w[3]), .irq_mask(irq_mask), .xirq_mask(xirq_mask),
    .wake(wake), .exit_kind(wake_ex)
  );

  assign cnt_clr = por || rst || (st != ST_WAIT);

  swc_delay_cnt #(.CYCLES(DELAY_CYC)) u_cnt (
    .clk(clk), .clr(cnt_clr), .done(cnt_done)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      st    <= ST_WAIT;
      ex_q  <= EX_RESET;
      dly_q <= 1'b1;
      nop_q <= 1'b0;
      res_q <= 1'b0;
      stk_q <= 1'b0;
      rgo_q <= 1'b0;
    end else begin
      nop_q <= 1'b0;
      res_q <= 1'b0;
      stk_q <= 1'b0;
      rgo_q <= 1'b0;
      if (rst) begin
        dly_q <= 1'b1;
        if (st == ST_RUN) begin
          rgo_q <= 1'b1;
        end else begin
          st   <= ST_WAIT;
          ex_q <= EX_RESET;
        end
      end else begin
        case (st)
          ST_RUN: begin
            if (dly_wr_en) dly_q <= dly_wr_val;
            if (stop_strobe) begin
              if (stop_dis) nop_q <= 1'b1;
              else          st    <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (wake) begin
              if (dly_q) begin
                st   <= ST_WAIT;
                ex_q <= wake_ex;
              end else begin
                st    <= ST_RUN;
                res_q <= (wake_ex == EX_RESUME);
                stk_q <= (wake_ex == EX_STACK);
              end
            end
          end
          ST_WAIT: begin
            if (cnt_done) begin
              st    <= ST_RUN;
              res_q <= (ex_q == EX_RESUME);
              stk_q <= (ex_q == EX_STACK);
              rgo_q <= (ex_q == EX_RESET);
            end
          end
          default: st <= ST_WAIT;
        endcase
      end
    end
  end

  assign core_en      = (st == ST_RUN);
  assign osc_en       = (st != ST_STOP);
  assign delay_busy   = (st == ST_WAIT);
  assign nop_pulse    = nop_q;
  assign resume_pulse = res_q;
  assign stack_pulse  = stk_q;
  assign reset_go     = rgo_q;
  assign dly_bit      = dly_q;
endmodule

// File: rtl/swc_chk.sv
module swc_chk (
  input logic clk,
  input logic por,
  input logic rst,
  input logic stop_strobe,
  input logic stop_dis,
  input logic osc_en,
  input logic core_en,
  input logic nop_pulse,
  input logic resume_pulse,
  input logic stack_pulse,
  input logic reset_go,
  input logic delay_busy,
  input logic dly_bit
);
  // R1
  nop_keeps_run_chk: assert property (@(posedge clk) disable iff (por)
    (stop_strobe && stop_dis && core_en && !rst) |=> (nop_pulse && core_en));

  // R2
  stop_gates_clocks_chk: assert property (@(posedge clk) disable iff (por)
    (stop_strobe && !stop_dis && core_en && !rst) |=> (!core_en && !osc_en));

  // R4
  one_exit_kind_chk: assert property (@(posedge clk) disable iff (por)
    $onehot0({nop_pulse, resume_pulse, stack_pulse, reset_go}));

  // R7
  busy_osc_only_chk: assert property (@(posedge clk) disable iff (por)
    delay_busy |-> (osc_en && !core_en));

  // R8
  no_delay_when_clear_chk: assert property (@(posedge clk) disable iff (por)
    (!osc_en && !dly_bit && !rst) |=> !delay_busy);

  // R9
  reset_in_stop_delays_chk: assert property (@(posedge clk) disable iff (por)
    (rst && !core_en) |=> (delay_busy && dly_bit));

  // R10
  reset_running_chk: assert property (@(posedge clk) disable iff (por)
    (rst && core_en) |=> (core_en && reset_go && !delay_busy));

  // R13
  strobe_idle_chk: assert property (@(posedge clk) disable iff (por)
    (!core_en && !rst) |=> !nop_pulse);
endmodule

bind stop_wake_ctrl swc_chk i_swc_chk (
  .clk(clk), .por(por), .rst(rst), .stop_strobe(stop_strobe),
  .stop_dis(stop_dis), .osc_en(osc_en), .core_en(core_en),
  .nop_pulse(nop_pulse), .resume_pulse(resume_pulse),
  .stack_pulse(stack_pulse), .reset_go(reset_go),
  .delay_busy(delay_busy), .dly_bit(dly_bit)
);

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 16;

  logic clk = 1'b0;
  logic por = 1'b1, rst = 1'b0, stop_strobe = 1'b0, stop_dis = 1'b0;
  logic irq_mask = 1'b1, xirq_mask = 1'b1, irq_n = 1'b1, xirq_n = 1'b1;
  logic kbd_req = 1'b0, edge_pend = 1'b0, dly_wr_en = 1'b0, dly_wr_val = 1'b0;
  logic osc_en, core_en, nop_pulse, resume_pulse, stack_pulse, reset_go;
  logic delay_busy, dly_bit;

  int total = 0, bad = 0, cycles = 0;
  bit started = 0, finished = 0;

  stop_wake_ctrl #(.DELAY_CYC(DLY), .SYNC_STAGES(2)) i_stop_wake_ctrl (
    .clk(clk), .por(por), .rst(rst), .stop_strobe(stop_strobe),
    .stop_dis(stop_dis), .irq_mask(irq_mask), .xirq_mask(xirq_mask),
    .irq_n(irq_n), .xirq_n(xirq_n), .kbd_req(kbd_req), .edge_pend(edge_pend),
    .dly_wr_en(dly_wr_en), .dly_wr_val(dly_wr_val), .osc_en(osc_en),
    .core_en(core_en), .nop_pulse(nop_pulse), .resume_pulse(resume_pulse),
    .stack_pulse(stack_pulse), .reset_go(reset_go), .delay_busy(delay_busy),
    .dly_bit(dly_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 run, 1 stopped, 2 delaying; exits 0 resume, 1 stack, 2 reset
  int m_st = 2, m_ex = 2, m_cnt = 0;
  bit m_dly = 1, m_nop = 0, m_res = 0, m_stk = 0, m_rgo = 0;
  logic [3:0] m_s1 = 4'b0011, m_s2 = 4'b0011;

  always @(posedge clk) begin
    bit wk, xl, done;
    int wex, old_st;
    started = 1;
    cycles++;
    old_st = m_st;
    xl   = !m_s2[1];
    wk   = (!m_s2[0] && !irq_mask) || xl || m_s2[2] || m_s2[3];
    wex  = (xl && !xirq_mask) ? 1 : 0;
    done = (m_st == 2) && (m_cnt == DLY - 1);
    m_nop = 0; m_res = 0; m_stk = 0; m_rgo = 0;
    if (por) begin
      m_st = 2; m_ex = 2; m_dly = 1; m_s1 = 4'b0011; m_s2 = 4'b0011;
    end else begin
      m_s2 = m_s1;
      m_s1 = {edge_pend, kbd_req, xirq_n, irq_n};
      if (rst) begin
        m_dly = 1;
        if (m_st == 0) m_rgo = 1;
        else begin m_st = 2; m_ex = 2; end
      end else if (m_st == 0) begin
        if (dly_wr_en) m_dly = dly_wr_val;
        if (stop_strobe) begin
          if (stop_dis) m_nop = 1; else m_st = 1;
        end
      end else if (m_st == 1) begin
        if (wk) begin
          if (m_dly) begin m_st = 2; m_ex = wex; end
          else begin m_st = 0; m_res = (wex == 0); m_stk = (wex == 1); end
        end
      end else if (done) begin
        m_st = 0; m_res = (m_ex == 0); m_stk = (m_ex == 1); m_rgo = (m_ex == 2);
      end
    end
    if (por || rst || old_st != 2) m_cnt = 0; else m_cnt++;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(core_en, m_st == 0, "R2 core_en model");
      chk(osc_en, m_st != 1, "R2 osc_en model");
      chk(delay_busy, m_st == 2, "R7 delay_busy model");
      chk(nop_pulse, m_nop, "R1 nop_pulse model");
      chk(resume_pulse, m_res, "R5 resume_pulse model");
      chk(stack_pulse, m_stk, "R4 stack_pulse model");
      chk(reset_go, m_rgo, "R9 reset_go model");
      chk(dly_bit, m_dly, "R12 dly_bit model");
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_stop();
    stop_strobe = 1; tick(1); stop_strobe = 0;
  endtask

  // counts busy cycles until core_en rises; returns pulses seen then
  task automatic measure(output int busy, output bit res, output bit stk, output bit rgo);
    busy = 0;
    for (int i = 0; i < 100 && !core_en; i++) begin
      if (delay_busy) begin
        busy++;
        chk(osc_en, 1, "R7 osc_en during delay");
      end
      tick(1);
    end
    res = resume_pulse; stk = stack_pulse; rgo = reset_go;
  endtask

  initial begin
    int b;
    bit r, s, g;
    tick(3);
    por = 0;
    chk(delay_busy, 1, "R11 busy after por");
    chk(core_en, 0, "R11 core off after por");
    chk(dly_bit, 1, "R11 dly set by por");
    measure(b, r, s, g);
    chk(b, DLY, "R11 por delay length");
    chk(g, 1, "R11 reset_go after por delay");

    dly_wr_en = 1; dly_wr_val = 0; tick(1); dly_wr_en = 0;
    chk(dly_bit, 0, "R12 software clear");

    stop_dis = 1; enter_stop(); stop_dis = 0;
    chk(nop_pulse, 1, "R1 nop reported");
    chk(core_en, 1, "R1 stays running");

    enter_stop();
    chk(core_en, 0, "R2 core stopped");
    chk(osc_en, 0, "R2 osc stopped");
    tick(4);
    chk(core_en, 0, "R2 stays stopped");

    stop_dis = 1; stop_strobe = 1; tick(1); stop_strobe = 0; stop_dis = 0;
    chk(nop_pulse, 0, "R13 strobe ignored when stopped");
    chk(osc_en, 0, "R13 osc unchanged");

    irq_mask = 1; irq_n = 0; tick(5);
    chk(core_en, 0, "R3 masked irq no wake");
    irq_mask = 0; tick(1);
    chk(core_en, 1, "R3 unmasked irq wakes");
    chk(resume_pulse, 1, "R3 resume after irq");
    irq_n = 1; irq_mask = 1; tick(3);

    enter_stop(); kbd_req = 1; tick(2);
    chk(core_en, 0, "R6 not yet through sync");
    tick(1);
    chk(core_en, 1, "R6 wake after two sync stages");
    chk(resume_pulse, 1, "R5 kbd resume");
    kbd_req = 0; tick(3);

    xirq_mask = 0; enter_stop(); xirq_n = 0; tick(3);
    chk(stack_pulse, 1, "R4 stack on unmasked xirq");
    chk(resume_pulse, 0, "R4 no resume on unmasked xirq");
    xirq_n = 1; tick(3);

    xirq_mask = 1; enter_stop(); xirq_n = 0; tick(3);
    chk(core_en, 1, "R4 masked xirq wakes");
    chk(resume_pulse, 1, "R4 masked xirq resumes");
    chk(stack_pulse, 0, "R4 masked xirq no stack");
    tick(1);
    chk(stack_pulse, 0, "R4 no pending xirq");
    xirq_n = 1; tick(3);

    enter_stop(); edge_pend = 1; tick(3);
    chk(resume_pulse, 1, "R5 edge pending resume");
    chk(delay_busy, 0, "R8 no delay with dly clear");
    edge_pend = 0; tick(3);

    kbd_req = 1; tick(3); enter_stop();
    chk(core_en, 0, "R14 one stopped cycle");
    tick(1);
    chk(core_en, 1, "R14 passes through");
    chk(resume_pulse, 1, "R14 resume");
    kbd_req = 0; tick(3);

    dly_wr_en = 1; dly_wr_val = 1; tick(1); dly_wr_en = 0;
    enter_stop(); kbd_req = 1;
    measure(b, r, s, g);
    chk(b, DLY, "R7 delayed wake length");
    chk(r, 1, "R7 resume after delay");
    kbd_req = 0; tick(3);

    dly_wr_en = 1; dly_wr_val = 0; tick(1); dly_wr_en = 0;
    enter_stop(); tick(2);
    rst = 1; tick(1); rst = 0;
    chk(dly_bit, 1, "R12 dly set by rst");
    measure(b, r, s, g);
    chk(b, DLY, "R9 reset-from-stop delay");
    chk(g, 1, "R9 reset_go");
    chk(r, 0, "R9 no resume");

    rst = 1; tick(1); rst = 0;
    chk(reset_go, 1, "R10 reset while running");
    chk(core_en, 1, "R10 core stays on");
    chk(delay_busy, 0, "R10 no delay");
    tick(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule